// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block passes short command words between two independently clocked ports through two 36-bit holding registers, one per direction. Port A deposits a word into the first register (mail1), which port B picks up. Port B deposits a word into the second register (mail2), which port A picks up. Each register has an active-low full indication. The writer uses it to know when the previous word has been consumed. A new word cannot overwrite one that has not been collected.

Each port has an enable, a direction select (1 = write, 0 = read), a mailbox select and a 36-bit input bus. A port-A access with the mailbox select high goes to the mailbox. The same is true for port B. Port A's output bus always shows mail2. Port B's output bus shows mail1 when its mailbox select is high, and otherwise passes a word from an external queue through unchanged. Occupancy is tracked by one toggle bit on the writer side and one on the reader side. Each bit is carried to the other clock through a two-flop synchroniser, so no set or clear event is ever lost.

Top module: `mbox_pair`

## Requirements
- R1: A port-A write (en=1, wr=1, sel=1) while `mbf1_n` is high stores `a_din` into mail1, and `mbf1_n` is low right after that clk_a edge.
- R2: A port-B write (en=1, wr=1, sel=1) while `mbf2_n` is high stores `b_din` into mail2, and `mbf2_n` is low right after that clk_b edge.
- R3: A write attempt to a mailbox whose flag is low leaves that mailbox's contents and flag unchanged.
- R4: A port-B read (en=1, wr=0, sel=1) of a full mail1 returns `mbf1_n` to high within four clk_a edges, once the full state has reached clk_b through the two-flop synchroniser.
- R5: A port-A read (en=1, wr=0, sel=1) of a full mail2 returns `mbf2_n` to high within four clk_b edges, with the same synchroniser rule.
- R6: Reads never change mailbox contents. A register changes only on an accepted write.
- R7: `b_dout` equals mail1 while `b_sel` is 1 and equals `fifo_din` while `b_sel` is 0.
- R8: `a_dout` always equals mail2.
- R9: After reset both flags are high (empty) and both registers hold zero.
- R10: Accesses with sel=0 or en=0 have no effect on either register or either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| clk_a | input | 1 | Port A clock |
| a_en | input | 1 | Port A access enable |
| a_wr | input | 1 | Port A direction, 1 = write, 0 = read |
| a_sel | input | 1 | Port A mailbox select |
| a_din | input | W | Port A write data |
| a_dout | output | W | Port A read data, always mail2 |
| mbf1_n | output | 1 | Mail1 full flag, active low, clk_a domain |
| clk_b | input | 1 | Port B clock |
| b_en | input | 1 | Port B access enable |
| b_wr | input | 1 | Port B direction, 1 = write, 0 = read |
| b_sel | input | 1 | Port B mailbox select, also steers b_dout |
| b_din | input | W | Port B write data |
| fifo_din | input | W | Queue word passed to b_dout when b_sel is 0 |
| b_dout | output | W | Port B read data |
| mbf2_n | output | 1 | Mail2 full flag, active low, clk_b domain |

## Verification
The bench targets a second write to a full mailbox. A design that let it through would overwrite the unread word, and the following read would return the wrong value. It issues reads and writes with the select or enable low. A design that decoded too loosely would clear a flag or load a register from queue traffic. It also checks that the flag comes back after a read and that the next write is accepted. A lost toggle event would leave the flag stuck low, or would leave it high while data is still pending. A seeded random mix of all four access kinds, with the output steering checked in both select states, covers the remaining interleavings.

// File: rtl/mbox_pair.sv
module mbox_pair #(
  parameter int W    = 36,
  parameter int SYNC = 2
) (
  input  logic         rst_n,
  input  logic         clk_a,
  input  logic         a_en,
  input  logic         a_wr,
  input  logic         a_sel,
  input  logic [W-1:0] a_din,
  output logic [W-1:0] a_dout,
  output logic         mbf1_n,
  input  logic         clk_b,
  input  logic         b_en,
  input  logic         b_wr,
  input  logic         b_sel,
  input  logic [W-1:0] b_din,
  input  logic [W-1:0] fifo_din,
  output logic [W-1:0] b_dout,
  output logic         mbf2_n
);
  localparam int L = SYNC - 1;

  logic [W-1:0] mail1, mail2;
  logic wtog1, rtog2;
  logic wtog2, rtog1;
  logic [L:0] rs1_a, ws2_a, ws1_b, rs2_b;

  logic full2_a, full1_b;
  logic a_put, a_take, b_put, b_take;

  assign mbf1_n  = ~(wtog1 ^ rs1_a[L]);
  assign full2_a = ws2_a[L] ^ rtog2;
  assign a_put   = a_en & a_sel & a_wr & mbf1_n;
  assign a_take  = a_en & a_sel & ~a_wr & full2_a;

  assign mbf2_n  = ~(wtog2 ^ rs2_b[L]);
  assign full1_b = ws1_b[L] ^ rtog1;
  assign b_put   = b_en & b_sel & b_wr & mbf2_n;
  assign b_take  = b_en & b_sel & ~b_wr & full1_b;

  assign a_dout = mail2;
  assign b_dout = b_sel ? mail1 : fifo_din;

  always_ff @(posedge clk_a or negedge rst_n) begin
    if (!rst_n) begin
      mail1 <= '0;
      wtog1 <= 1'b0;
      rtog2 <= 1'b0;
      rs1_a <= '0;
      ws2_a <= '0;
    end else begin
      rs1_a <= {rs1_a[L-1:0], rtog1};
      ws2_a <= {ws2_a[L-1:0], wtog2};
      if (a_put) begin
        mail1 <= a_din;
        wtog1 <= ~wtog1;
      end
      if (a_take) rtog2 <= ~rtog2;
    end
  end

  always_ff @(posedge clk_b or negedge rst_n) begin
    if (!rst_n) begin
      mail2 <= '0;
      wtog2 <= 1'b0;
      rtog1 <= 1'b0;
      ws1_b <= '0;
      rs2_b <= '0;
    end else begin
      ws1_b <= {ws1_b[L-1:0], wtog1};
      rs2_b <= {rs2_b[L-1:0], rtog2};
      if (b_put) begin
        mail2 <= b_din;
        wtog2 <= ~wtog2;
      end
      if (b_take) rtog1 <= ~rtog1;
    end
  end

  p_put_fills_r1: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_en && a_sel && a_wr && mbf1_n) |=> (!mbf1_n && mail1 == $past(a_din)));

  p_put_fills_r2: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_en && b_sel && b_wr && mbf2_n) |=> (!mbf2_n && mail2 == $past(b_din)));

  p_locked_mail1_r3: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_en && a_sel && a_wr && !mbf1_n) |=> $stable(mail1));

  p_locked_mail2_r3: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_en && b_sel && b_wr && !mbf2_n) |=> $stable(mail2));

  p_unselected_a_r10: assert property (@(posedge clk_a) disable iff (!rst_n)
    (!a_sel && mbf1_n) |=> $stable(mail1));
endmodule

// File: tb/mbox_pair_tb_top.sv
module mbox_pair_tb_top;
  localparam int W = 36;

  logic rst_n = 1'b0;
  logic clk_a = 1'b0, clk_b = 1'b0;
  logic a_en = 0, a_wr = 0, a_sel = 0;
  logic b_en = 0, b_wr = 0, b_sel = 0;
  logic [W-1:0] a_din = '0, b_din = '0, fifo_din = '0;
  logic [W-1:0] a_dout, b_dout;
  logic mbf1_n, mbf2_n;

  int checks = 0, errors = 0;
  logic [W-1:0] m1 = '0, m2 = '0;
  bit f1 = 0, f2 = 0;

  always #5 clk_a = ~clk_a;
  initial begin #3; forever #5 clk_b = ~clk_b; end

  mbox_pair #(.W(W), .SYNC(2)) dut_i (
    .rst_n(rst_n), .clk_a(clk_a), .a_en(a_en), .a_wr(a_wr), .a_sel(a_sel),
    .a_din(a_din), .a_dout(a_dout), .mbf1_n(mbf1_n),
    .clk_b(clk_b), .b_en(b_en), .b_wr(b_wr), .b_sel(b_sel),
    .b_din(b_din), .fifo_din(fifo_din), .b_dout(b_dout), .mbf2_n(mbf2_n));

  function automatic logic [W-1:0] rnd_word();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[W-1:0];
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk_b);
    repeat (4) @(posedge clk_a);
    @(negedge clk_a);
  endtask

  task automatic check_all(input string tag);
    logic [W-1:0] q;
    chk({tag, " R4 mbf1_n"}, W'(mbf1_n), W'(!f1));
    chk({tag, " R5 mbf2_n"}, W'(mbf2_n), W'(!f2));
    chk({tag, " R8 a_dout"}, a_dout, m2);
    @(negedge clk_b);
    b_sel = 1'b1; #1;
    chk({tag, " R7 b_dout mail1"}, b_dout, m1);
    q = rnd_word();
    fifo_din = q; b_sel = 1'b0; #1;
    chk({tag, " R7 b_dout fifo"}, b_dout, q);
  endtask

  task automatic op_a(input bit en, input bit wr, input bit sel, input logic [W-1:0] d);
    bit acc;
    acc = en && sel && wr && !f1;
    @(negedge clk_a);
    a_en = en; a_wr = wr; a_sel = sel; a_din = d;
    @(posedge clk_a); #1;
    if (acc) chk("R1 mbf1_n low after write", W'(mbf1_n), W'(0));
    @(negedge clk_a);
    a_en = 0; a_wr = 0; a_sel = 0;
    if (en && sel) begin
      if (wr) begin if (!f1) begin m1 = d; f1 = 1; end end
      else f2 = 0;
    end
    settle();
  endtask

  task automatic op_b(input bit en, input bit wr, input bit sel, input logic [W-1:0] d);
    bit acc;
    acc = en && sel && wr && !f2;
    @(negedge clk_b);
    b_en = en; b_wr = wr; b_sel = sel; b_din = d;
    @(posedge clk_b); #1;
    if (acc) chk("R2 mbf2_n low after write", W'(mbf2_n), W'(0));
    @(negedge clk_b);
    b_en = 0; b_wr = 0; b_sel = 0;
    if (en && sel) begin
      if (wr) begin if (!f2) begin m2 = d; f2 = 1; end end
      else f1 = 0;
    end
    settle();
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk_a);
    rst_n = 1'b1;
    settle();
    check_all("R9 reset");

    op_a(1, 1, 1, 36'h1_2345_6789);
    check_all("R1 first write");
    op_a(1, 1, 1, 36'hF_FFFF_0000);
    check_all("R3 write to full mail1");
    op_b(1, 0, 0, '0);
    check_all("R10 read sel low");
    op_b(0, 0, 1, '0);
    check_all("R10 read en low");
    op_b(1, 0, 1, '0);
    check_all("R4 read frees mail1, R6 data kept");
    op_a(1, 1, 1, 36'hA_BCDE_F012);
    check_all("R1 write after free");

    op_b(1, 1, 1, 36'h0_0000_00FF);
    check_all("R2 first write");
    op_b(1, 1, 1, 36'h5_5555_5555);
    check_all("R3 write to full mail2");
    op_a(1, 1, 0, 36'h3_3333_3333);
    check_all("R10 write sel low");
    op_a(1, 0, 1, '0);
    check_all("R5 read frees mail2, R6 data kept");

    for (int i = 0; i < 250; i++) begin
      bit side, en, wr, sel;
      logic [W-1:0] d;
      side = 1'($urandom_range(0, 1));
      en   = ($urandom_range(0, 7) != 0);
      wr   = 1'($urandom_range(0, 1));
      sel  = ($urandom_range(0, 5) != 0);
      d    = rnd_word();
      if (side) op_a(en, wr, sel, d);
      else op_b(en, wr, sel, d);
      check_all("R6 random mix");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule